// File: doc/BRIEF.md
# RAM Self-Test Controller

This controller takes over the single port of a small synchronous RAM and runs six test phases in a fixed order. It first fills the whole array with a checkerboard pattern, then with the opposite checkerboard pattern. It then holds a single set bit in circulation, then a single cleared bit. Finally it runs two address-line checks, one with a single address bit high and one with a single address bit low. Any mismatch ends the run at once. The controller then reports the address that failed and a code for the phase that was running.

The circulating tests work one cell at a time. The controller keeps a one-bit carry register beside the cell and rotates the cell left through that carry, DATA_W+1 times in all. Each rotation is a read followed by a write. After the last rotation, both the carry and the cell must be back at their starting values. The RAM returns read data one cycle after the read is issued. The settle delay, the address width and the data width are parameters.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, busy, done, pass and fail are low, fail_phase is 0 and mem_en is low.
- R2: A start sampled while the controller is idle or done begins a new run: on the next cycle busy is high, and done, pass and fail are low. A start sampled while busy has no effect on the run's result or its length.
- R3: Checkerboard phases fill every address with 8'hA5 (phase code 1), wait the settle delay, and read every address back and compare it. They then do the same with 8'h5A (phase code 2).
- R4: Walking-one phase (code 3): each cell is written with 0 and the carry is set to 1. The cell is then rotated left through the carry DATA_W+1 times. The run fails unless the carry ends at 1 and a final read returns 0.
- R5: Walking-zero phase (code 4): each cell is written with all ones and the carry is cleared, then it is rotated DATA_W+1 times. The run fails unless the carry ends at 0. The value read back plus one is written to the cell and must equal 0. This leaves every cell cleared when the phase passes.
- R6: Address-line phase (code 5): the controller writes to address 0 and to each address that has exactly one bit set. Entry k goes to address 0 for k=0 and to address 1<<(k-1) for k=1..ADDR_W. It holds the pattern k XOR 8'h3C. The controller waits the settle delay, then verifies the entries in order of k.
- R7: Inverted address-line phase (code 6): the same as R6, but it uses the all-ones address for k=0 and the address with only bit k-1 cleared for k=1..ADDR_W.
- R8: The first mismatch ends the run with done=1, fail=1 and pass=0. fail_addr holds the address being checked and fail_phase holds the phase code. All of these stay stable until the next start.
- R9: If all six phases pass, the run ends with pass=1, fail=0 and fail_phase=0. busy is high for exactly 2(3·2^A+S) + 2^A·(4W+10) + 2(3(A+1)+S) cycles, where A=ADDR_W, W=DATA_W and S=SETTLE.
- R10: mem_we is only high together with mem_en. mem_en is low whenever busy is low and during the settle delay.
- R11: busy and done are never high together. done stays high from the end of a run until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Starts a run when sampled while idle or done |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (valid with mem_en) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| pass | output | 1 | The last run found no fault |
| fail | output | 1 | The last run found a fault |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_phase | output | 3 | Phase code of the first mismatch (1..6), 0 if none |

## Verification
The assertions check the following on every cycle:
- the RAM port rules;
- that busy and done never overlap;
- that the verdict flags are consistent with the phase code;
- that results hold while done;
- that a start launches a run;
- that a passing walking-zero check always writes zero back.

Some behaviours only the bench's scenarios can show:
- which phase and which address catch a given cell or decoder fault;
- that a start pulse during a run changes nothing;
- the exact run length;
- the patterns left in memory after a clean run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_DELAY,
    ST_VERIFY,
    ST_WALK1,
    ST_WALK0,
    ST_ADDR,
    ST_ADDRINV,
    ST_DONE
  } st_e;

  // Phase codes as reported on fail_phase
  typedef enum logic [2:0] {
    PH_NONE    = 3'd0,
    PH_CHK_A   = 3'd1,
    PH_CHK_B   = 3'd2,
    PH_WALK1   = 3'd3,
    PH_WALK0   = 3'd4,
    PH_ADDR    = 3'd5,
    PH_ADDRINV = 3'd6
  } phase_e;

  // Sub-steps used by the verify sweep and the circulate tests
  typedef enum logic [2:0] {
    SS_INIT,
    SS_READ,
    SS_MODIFY,
    SS_FINAL,
    SS_CHECK
  } step_e;

endpackage

// File: rtl/mbist_reset_sync.sv
module mbist_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/mbist_addr_map.sv
module mbist_addr_map
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  phase_e              phase_i,
  input  logic [ADDR_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   pat_o,
  output logic [ADDR_W-1:0]   last_o
);

  localparam logic [DATA_W-1:0] PAT_A   = {(DATA_W/8){8'hA5}};
  localparam logic [DATA_W-1:0] PAT_B   = {(DATA_W/8){8'h5A}};
  localparam logic [DATA_W-1:0] PAT_SIG = {(DATA_W/8){8'h3C}};
  localparam logic [ADDR_W-1:0] LINE_LAST = ADDR_W'(ADDR_W);

  // Entry k (k >= 1) selects address bit k-1; entry 0 selects none
  logic [ADDR_W-1:0] line_sel;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_line_dec
      assign line_sel[gi] = (idx_i == ADDR_W'(gi + 1));
    end
  endgenerate

  always_comb begin
    addr_o = idx_i;
    pat_o  = '0;
    last_o = '1;
    case (phase_i)
      PH_CHK_A: pat_o = PAT_A;
      PH_CHK_B: pat_o = PAT_B;
      PH_ADDR: begin
        addr_o = line_sel;
        pat_o  = DATA_W'(idx_i) ^ PAT_SIG;
        last_o = LINE_LAST;
      end
      PH_ADDRINV: begin
        addr_o = ~line_sel;
        pat_o  = DATA_W'(idx_i) ^ PAT_SIG;
        last_o = LINE_LAST;
      end
      default: pat_o = '0;
    endcase
  end

endmodule

// File: rtl/mbist_rotor.sv
module mbist_rotor #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] rot_o,
  output logic              cout_o,
  output logic [DATA_W-1:0] inc_o
);

  assign rot_o  = {din_i[DATA_W-2:0], cin_i};
  assign cout_o = din_i[DATA_W-1];
  assign inc_o  = din_i + DATA_W'(1);

endmodule

// File: rtl/mbist_settle_timer.sv
module mbist_settle_timer #(
  parameter int SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam int LOAD  = SETTLE - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | (run_i & ~expired_o);

  always_comb begin
    if (load_i) begin
      cnt_d = CNT_W'(LOAD);
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_phase
);

  localparam int                ROT_W    = $clog2(DATA_W + 1);
  localparam logic [ROT_W-1:0]  ROT_LAST = ROT_W'(DATA_W);

  logic srst_n;

  st_e               st_q, st_d;
  phase_e            ph_q, ph_d;
  step_e             step_q, step_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [ROT_W-1:0]  rot_q, rot_d;
  logic              carry_q, carry_d;

  logic              pass_q, pass_d, fail_q, fail_d, res_en;
  logic [ADDR_W-1:0] fail_addr_q;
  phase_e            fail_phase_q;
  logic              cap_en, cap_clr;

  logic [ADDR_W-1:0] map_addr, map_last;
  logic [DATA_W-1:0] map_pat;
  logic [DATA_W-1:0] rot_dout, rot_inc;
  logic              rot_cout;
  logic              tmr_load, tmr_run, tmr_expired;
  logic              walk_one, walk_bad;

  mbist_reset_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mbist_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .phase_i (ph_q),
    .idx_i   (idx_q),
    .addr_o  (map_addr),
    .pat_o   (map_pat),
    .last_o  (map_last)
  );

  mbist_rotor #(.DATA_W(DATA_W)) u_rotor (
    .din_i  (mem_rdata),
    .cin_i  (carry_q),
    .rot_o  (rot_dout),
    .cout_o (rot_cout),
    .inc_o  (rot_inc)
  );

  mbist_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  assign walk_one = (st_q == ST_WALK1);

  // Next-state and port decode
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    step_d    = step_q;
    idx_d     = idx_q;
    rot_d     = rot_q;
    carry_d   = carry_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    res_en    = 1'b0;
    cap_en    = 1'b0;
    cap_clr   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = map_addr;
    mem_wdata = map_pat;
    tmr_load  = 1'b0;
    tmr_run   = 1'b0;
    walk_bad  = 1'b0;

    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d    = ST_FILL;
          ph_d    = PH_CHK_A;
          idx_d   = '0;
          res_en  = 1'b1;
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          cap_clr = 1'b1;
        end
      end

      ST_FILL, ST_ADDR, ST_ADDRINV: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        if (idx_q == map_last) begin
          st_d     = ST_DELAY;
          idx_d    = '0;
          tmr_load = 1'b1;
        end else begin
          idx_d = idx_q + ADDR_W'(1);
        end
      end

      ST_DELAY: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          st_d   = ST_VERIFY;
          step_d = SS_READ;
        end
      end

      ST_VERIFY: begin
        if (step_q == SS_READ) begin
          mem_en = 1'b1;
          step_d = SS_CHECK;
        end else if (mem_rdata != map_pat) begin
          st_d   = ST_DONE;
          res_en = 1'b1;
          fail_d = 1'b1;
          cap_en = 1'b1;
        end else if (idx_q != map_last) begin
          idx_d  = idx_q + ADDR_W'(1);
          step_d = SS_READ;
        end else begin
          idx_d  = '0;
          step_d = SS_INIT;
          case (ph_q)
            PH_CHK_A: begin
              st_d = ST_FILL;
              ph_d = PH_CHK_B;
            end
            PH_CHK_B: begin
              st_d = ST_WALK1;
              ph_d = PH_WALK1;
            end
            PH_ADDR: begin
              st_d = ST_ADDRINV;
              ph_d = PH_ADDRINV;
            end
            default: begin
              st_d   = ST_DONE;
              res_en = 1'b1;
              pass_d = 1'b1;
            end
          endcase
        end
      end

      ST_WALK1, ST_WALK0: begin
        case (step_q)
          SS_INIT: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = walk_one ? '0 : '1;
            carry_d   = walk_one;
            rot_d     = '0;
            step_d    = SS_READ;
          end
          SS_READ: begin
            mem_en = 1'b1;
            step_d = SS_MODIFY;
          end
          SS_MODIFY: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = rot_dout;
            carry_d   = rot_cout;
            if (rot_q == ROT_LAST) begin
              step_d = SS_FINAL;
            end else begin
              rot_d  = rot_q + ROT_W'(1);
              step_d = SS_READ;
            end
          end
          SS_FINAL: begin
            mem_en = 1'b1;
            step_d = SS_CHECK;
          end
          default: begin
            if (walk_one) begin
              walk_bad = !carry_q || (mem_rdata != '0);
            end else begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_wdata = rot_inc;
              walk_bad  = carry_q || (rot_inc != '0);
            end
            if (walk_bad) begin
              st_d   = ST_DONE;
              res_en = 1'b1;
              fail_d = 1'b1;
              cap_en = 1'b1;
            end else if (idx_q != map_last) begin
              idx_d  = idx_q + ADDR_W'(1);
              step_d = SS_INIT;
            end else begin
              idx_d  = '0;
              step_d = SS_INIT;
              if (walk_one) begin
                st_d = ST_WALK0;
                ph_d = PH_WALK0;
              end else begin
                st_d = ST_ADDR;
                ph_d = PH_ADDR;
              end
            end
          end
        endcase
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_NONE;
      step_q  <= SS_INIT;
      idx_q   <= '0;
      rot_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      step_q  <= step_d;
      idx_q   <= idx_d;
      rot_q   <= rot_d;
      carry_q <= carry_d;
    end
  end

  // Verdict registers, enabled only at run start and run end
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (res_en) begin
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  // Failure capture registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fail_addr_q  <= '0;
      fail_phase_q <= PH_NONE;
    end else if (cap_clr) begin
      fail_addr_q  <= '0;
      fail_phase_q <= PH_NONE;
    end else if (cap_en) begin
      fail_addr_q  <= mem_addr;
      fail_phase_q <= ph_q;
    end
  end

  assign busy       = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done       = (st_q == ST_DONE);
  assign pass       = pass_q;
  assign fail       = fail_q;
  assign fail_addr  = fail_addr_q;
  assign fail_phase = fail_phase_q;

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(busy && done));

  // R10
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> mem_en);

  // R10
  idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> !mem_en);

  // R10
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_DELAY) |-> !mem_en);

  // R8
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({pass, fail}));

  // R8
  fail_code_chk: assert property (@(posedge clk) disable iff (!srst_n)
    fail |-> (fail_phase != 3'd0) && done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !start) |=> (done && $stable(fail_addr) && $stable(fail_phase)
                          && $stable(pass) && $stable(fail)));

  // R9
  pass_code_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pass |-> (fail_phase == 3'd0));

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && start) |=> (busy && !pass && !fail));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && start) |=> (busy || done));

  // R5
  walk0_clears_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_WALK0 && step_q == SS_CHECK && st_d != ST_DONE)
      |-> (mem_we && mem_wdata == '0));

endmodule

// File: tb/mbist_ctrl_tb.sv
module mbist_ctrl_tb;

  localparam int A = 8;
  localparam int W = 8;
  localparam int S = 16;
  localparam int D = 1 << A;
  localparam int RUN_CLEAN = 2 * (3 * D + S) + D * (4 * W + 10) + 2 * (3 * (A + 1) + S);

  localparam int FM_NONE   = 0;
  localparam int FM_STUCK1 = 1;
  localparam int FM_STUCK0 = 2;
  localparam int FM_ZSET   = 3;
  localparam int FM_FCLR   = 4;
  localparam int FM_DROP   = 5;
  localparam int FM_ALIAS  = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mem_en, mem_we;
  logic [A-1:0] mem_addr;
  logic [W-1:0] mem_wdata;
  logic [W-1:0] mem_rdata;
  logic         busy, done, pass, fail;
  logic [A-1:0] fail_addr;
  logic [2:0]   fail_phase;

  int n_checks = 0;
  int n_fail   = 0;
  int port_bad = 0;
  int busy_cnt = 0;
  bit done_seen = 1'b0;

  int           fmode = FM_NONE;
  logic [A-1:0] faddr = '0;
  int           fbit  = 0;

  logic [W-1:0] ram [0:D-1];

  typedef struct {
    bit           ok;
    logic [2:0]   phase;
    logic [A-1:0] addr;
    int           cycles;
    string        tag;
  } exp_t;

  exp_t sb [$];

  always #5 clk = ~clk;

  mbist_ctrl #(.ADDR_W(A), .DATA_W(W), .SETTLE(S)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_phase (fail_phase)
  );

  function automatic logic [A-1:0] phys(input logic [A-1:0] a);
    if (fmode == FM_DROP)  return a & ~(A'(1) << fbit);
    if (fmode == FM_ALIAS) return (a == '1) ? {{(A-1){1'b1}}, 1'b0} : a;
    return a;
  endfunction

  function automatic logic [W-1:0] stored(input logic [A-1:0] a, input logic [W-1:0] v);
    logic [W-1:0] m;
    m = W'(1) << fbit;
    if (a != faddr) return v;
    case (fmode)
      FM_STUCK1: return v | m;
      FM_STUCK0: return v & ~m;
      FM_ZSET:   return (v == '0) ? (v | m) : v;
      FM_FCLR:   return (v == '1) ? (v & ~m) : v;
      default:   return v;
    endcase
  endfunction

  // RAM model with one cycle of read latency and injectable faults
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[phys(mem_addr)] <= stored(mem_addr, mem_wdata);
      else        mem_rdata <= ram[phys(mem_addr)];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_cell(input int a);
    if (a == 0 || a == D - 1) return 8'h3C;
    for (int i = 0; i < A; i++) begin
      if (a == (1 << i) || a == ((D - 1) ^ (1 << i))) return W'(i + 1) ^ 8'h3C;
    end
    return '0;
  endfunction

  // Monitor: port rules and scoreboard compare at the end of each run
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_we && !mem_en) || (mem_en && !busy)) port_bad++;
      if (busy) busy_cnt++;
      if (done && !done_seen) begin
        check(!busy, "R11", "busy with done", 32'(busy), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(pass == e.ok, e.tag, "pass flag", 32'(pass), 32'(e.ok));
          check(fail == !e.ok, e.tag, "fail flag", 32'(fail), 32'(!e.ok));
          check(fail_phase == e.phase, e.tag, "fail_phase", 32'(fail_phase), 32'(e.phase));
          if (!e.ok)
            check(fail_addr == e.addr, e.tag, "fail_addr", 32'(fail_addr), 32'(e.addr));
          if (e.cycles != 0)
            check(busy_cnt == e.cycles, e.tag, "busy cycles", 32'(busy_cnt), 32'(e.cycles));
        end
        busy_cnt = 0;
      end
      done_seen = done;
    end
  end

  // Driver: arms a fault, queues the expectation, runs one test
  task automatic run_case(input int mode, input logic [A-1:0] fa, input int fb,
                          input bit ok, input logic [2:0] ph, input logic [A-1:0] ea,
                          input int cyc, input bit mid, input string tag);
    exp_t e;
    logic [A-1:0] held_addr;
    logic [2:0]   held_phase;
    for (int i = 0; i < D; i++) ram[i] = '0;
    fmode = mode;
    faddr = fa;
    fbit  = fb;
    e.ok = ok; e.phase = ph; e.addr = ea; e.cycles = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && !done && !pass && !fail && fail_phase == 3'd0, "R2", "launch flags",
          {27'd0, busy, done, pass, fail, 1'b0}, 32'h10);
    if (mid) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    held_addr  = fail_addr;
    held_phase = fail_phase;
    repeat (6) @(negedge clk);
    check(done && fail_addr == held_addr && fail_phase == held_phase, "R8", "hold after done",
          {21'd0, done, fail_phase, fail_addr}, {21'd0, 1'b1, held_phase, held_addr});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int bad_true, bad_inv, bad_rest;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !fail && fail_phase == 3'd0 && !mem_en, "R1",
          "flags in reset", {26'd0, busy, done, pass, fail, mem_en, |fail_phase}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !pass && !fail && !mem_en, "R1", "flags after release",
          {27'd0, busy, done, pass, fail, mem_en}, 0);

    // R9 clean run with exact length
    run_case(FM_NONE, '0, 0, 1'b1, 3'd0, '0, RUN_CLEAN, 1'b0, "R9");

    // Memory image left by a passing run: R5 zeros, R6/R7 address-line patterns
    bad_true = 0; bad_inv = 0; bad_rest = 0;
    for (int a = 0; a < D; a++) begin
      if (ram[a] != exp_cell(a)) begin
        if (a == 0 || $countones(a) == 1) bad_true++;
        else if ($countones(a) >= A - 1) bad_inv++;
        else bad_rest++;
      end
    end
    check(bad_true == 0, "R6", "one-hot cells wrong", 32'(bad_true), 0);
    check(bad_inv == 0, "R7", "one-cold cells wrong", 32'(bad_inv), 0);
    check(bad_rest == 0, "R5", "non-zero other cells", 32'(bad_rest), 0);

    // R3 checkerboard A: bit 3 stuck high at 0x40 (A5 has bit 3 low)
    run_case(FM_STUCK1, 8'h40, 3, 1'b0, 3'd1, 8'h40, D + S + 2 * (8'h40 + 1), 1'b0, "R3");
    // R3 checkerboard A: bit 2 stuck low at 0x81
    run_case(FM_STUCK0, 8'h81, 2, 1'b0, 3'd1, 8'h81, 0, 1'b0, "R3");
    // R3 checkerboard B: bit 0 stuck high at 0x22 passes A5, fails 5A
    run_case(FM_STUCK1, 8'h22, 0, 1'b0, 3'd2, 8'h22, 0, 1'b0, "R3");
    // R4 writing zero sets bit 4 at 0x37
    run_case(FM_ZSET, 8'h37, 4, 1'b0, 3'd3, 8'h37, 0, 1'b0, "R4");
    // R5 writing all ones clears bit 6 at 0xC3
    run_case(FM_FCLR, 8'hC3, 6, 1'b0, 3'd4, 8'hC3, 0, 1'b0, "R5");
    // R6 address bit 5 ignored by decoder: address 0 overwritten
    run_case(FM_DROP, '0, 5, 1'b0, 3'd5, 8'h00, 0, 1'b0, "R6");
    // R7 all-ones address aliases onto 0xFE
    run_case(FM_ALIAS, '0, 0, 1'b0, 3'd6, 8'hFF, 0, 1'b0, "R7");
    // R2 start during a run is ignored: same verdict, same length
    run_case(FM_NONE, '0, 0, 1'b1, 3'd0, '0, RUN_CLEAN, 1'b1, "R2");

    check(port_bad == 0, "R10", "port rule breaches", 32'(port_bad), 0);
    check(sb.size() == 0, "R8", "pending expectations", 32'(sb.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule